// File: doc/BRIEF.md
# Rotating-Spare Segmented Adder

This block is a clocked adder built from a row of equal-width ripple segments. A small prefix network over the segment generate and propagate terms supplies each segment's carry-in. One extra ripple segment, the spare, is the same width as the working segments. In every cycle the spare takes over the operand slice of one working segment, chosen in rotation, and delivers that slice's result. The displaced segment is fed a fixed self-test vector, and its result is compared with the known answer in the same cycle.

When a displaced segment returns a wrong answer, the block flags an error. The spare then stays bound to that segment's slice for good, and rotation stops. From then on no segment is tested, so faults that appear later in other segments reach the sum unchecked. The sum, carry-out and status outputs are registered. Each result appears one clock after its operands are presented.

For verification, each working segment has a fault-injection input. A set bit inverts the least significant sum bit of that segment.

Top module: `gd_spare_adder`

## Requirements
- R1: With no fault injected, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` sampled at the previous rising clock edge, in every cycle of the rotation.
- R2: After reset the serviced segment index starts at 0 and advances 0, 1, 2, 3, 0, ... once per clock cycle while the block is not degraded; a fault held on segment k from reset release is detected in cycle k, where cycle 0 is the first clock edge after reset release.
- R3: The self-test drives the displaced segment with a = all ones, b = 1, carry-in = 0, and expects a zero sum with carry-out 1, compared combinationally in that cycle. Setting `fault_i[k]` inverts bit 0 of segment k's sum (output bit k*8 at default parameters) whenever segment k feeds the output.
- R4: In the cycle in which segment k is displaced, the spare's result fills slice k, so a fault on segment k does not corrupt that cycle's sum.
- R5: On a failed self-test, `err_o` is high for exactly one cycle, starting with the registered result of the failing cycle, and `degraded_o` rises in the same cycle.
- R6: On a failed self-test, `repl_idx_o` takes the index of the failing segment.
- R7: Once degraded, the spare permanently serves the replaced segment's slice: a fault on the replaced segment has no effect on `sum_o`.
- R8: Once degraded, no self-test runs: faults on other segments pass into `sum_o` and `err_o` stays low.
- R9: While `rst_n` is low, `sum_o`, `cout_o`, `err_o`, `repl_idx_o` and `degraded_o` are all zero.
- R10: `degraded_o` and `repl_idx_o` hold until reset; a reset clears them and rotation restarts at segment 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | SEG_W*NUM_SEG | First operand |
| b_i | input | SEG_W*NUM_SEG | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| fault_i | input | NUM_SEG | Per-segment fault injection, inverts segment sum bit 0 |
| sum_o | output | SEG_W*NUM_SEG | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| err_o | output | 1 | One-cycle pulse on a failed self-test |
| repl_idx_o | output | clog2(NUM_SEG) | Index of the permanently replaced segment |
| degraded_o | output | 1 | Spare permanently bound, checking ended |

## Verification
The bench holds a fault on each segment in turn from reset release and checks that detection lands exactly in that segment's rotation slot. A design with a wrong rotation order or an off-by-one pointer would report the error early, late, or against the wrong index. It also checks that the cycle in which a faulty segment is displaced still gives a clean sum, and that the cycles before detection carry the corrupted bit, which a wrong slice mux would hide or misplace. After degradation it injects faults on both the replaced segment and a different one. A design that kept checking, or that released the spare, would raise a second error or let the replaced segment's fault leak into the sum.

// File: rtl/gd_pkg.sv
package gd_pkg;

  localparam int MAXW = 64;

  typedef logic [MAXW-1:0] wide_t;

  // one-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // one-bit full adder, carry output
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // carry a w-bit slice produces on its own (carry-in 0)
  function automatic logic grp_gen(input wide_t x, input wide_t y, input int w);
    logic c;
    c = 1'b0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < w) c = fa_carry(x[i], y[i], c);
    end
    return c;
  endfunction

  // slice passes an incoming carry straight through
  function automatic logic grp_prop(input wide_t x, input wide_t y, input int w);
    logic p;
    p = 1'b1;
    for (int i = 0; i < MAXW; i++) begin
      if (i < w) p = p & (x[i] ^ y[i]);
    end
    return p;
  endfunction

  // prefix combine of (g,p) pairs: left is the more significant group
  function automatic logic [1:0] gp_merge(input logic gl, input logic pl,
                                          input logic gr, input logic pr);
    return {gl | (pl & gr), pl & pr};
  endfunction

endpackage

// File: rtl/gd_ripple_seg.sv
module gd_ripple_seg #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             ci_i,
  input  logic             flip_i,
  output logic [SEG_W-1:0] s_o,
  output logic             co_o
);
  import gd_pkg::*;

  logic [SEG_W:0]   chain;
  logic [SEG_W-1:0] raw;

  assign chain[0] = ci_i;

  for (genvar i = 0; i < SEG_W; i++) begin : g_bit
    assign raw[i]      = fa_sum(a_i[i], b_i[i], chain[i]);
    assign chain[i+1]  = fa_carry(a_i[i], b_i[i], chain[i]);
  end

  // injected fault: low sum bit inverted
  assign s_o  = raw ^ SEG_W'(flip_i);
  assign co_o = chain[SEG_W];

endmodule

// File: rtl/gd_carry_tree.sv
module gd_carry_tree #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 4
) (
  input  logic [SEG_W*NUM_SEG-1:0] a_i,
  input  logic [SEG_W*NUM_SEG-1:0] b_i,
  input  logic                     cin_i,
  output logic [NUM_SEG-1:0]       seg_cin_o
);
  import gd_pkg::*;

  // only the lower NUM_SEG-1 groups feed another segment
  localparam int NT  = NUM_SEG - 1;
  localparam int LVL = (NT > 1) ? $clog2(NT) : 0;

  logic [NT-1:0]         g0, p0;
  logic [LVL:0][NT-1:0]  gl, pl;

  for (genvar i = 0; i < NT; i++) begin : g_grp
    assign g0[i] = grp_gen (wide_t'(a_i[i*SEG_W +: SEG_W]), wide_t'(b_i[i*SEG_W +: SEG_W]), SEG_W);
    assign p0[i] = grp_prop(wide_t'(a_i[i*SEG_W +: SEG_W]), wide_t'(b_i[i*SEG_W +: SEG_W]), SEG_W);
    if (i == 0) begin : g_base
      assign gl[0][0] = g0[0] | (p0[0] & cin_i);
      assign pl[0][0] = p0[0];
    end else begin : g_other
      assign gl[0][i] = g0[i];
      assign pl[0][i] = p0[i];
    end
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < NT; i++) begin : g_node
      if (i >= D) begin : g_merge
        assign {gl[l+1][i], pl[l+1][i]} = gp_merge(gl[l][i], pl[l][i], gl[l][i-D], pl[l][i-D]);
      end else begin : g_pass
        assign gl[l+1][i] = gl[l][i];
        assign pl[l+1][i] = pl[l][i];
      end
    end
  end

  assign seg_cin_o[0] = cin_i;
  for (genvar i = 0; i < NT; i++) begin : g_out
    assign seg_cin_o[i+1] = gl[LVL][i];
  end

endmodule

// File: rtl/gd_selftest.sv
module gd_selftest #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 4,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_s_i,
  input  logic [NUM_SEG-1:0]            seg_co_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          enable_i,
  output logic                          fail_o
);
  // known answer for the self-test vector
  localparam logic [SEG_W-1:0] TA = '1;
  localparam logic [SEG_W-1:0] TB = SEG_W'(1);
  localparam logic [SEG_W:0]   TR = {1'b0, TA} + {1'b0, TB};

  logic [SEG_W-1:0] got_s;
  logic             got_co;

  assign got_s  = seg_s_i[idx_i];
  assign got_co = seg_co_i[idx_i];
  assign fail_o = enable_i && ((got_s != TR[SEG_W-1:0]) || (got_co != TR[SEG_W]));

endmodule

// File: rtl/gd_rotor.sv
module gd_rotor #(
  parameter int NUM_SEG = 4,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             deg_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1);

  logic [IDX_W-1:0] ptr_q, idx_q;
  logic             deg_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
      deg_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!deg_q) begin
        if (fail_i) begin
          deg_q <= 1'b1;
          idx_q <= ptr_q;
          err_q <= 1'b1;
        end else begin
          ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
      end
    end
  end

  assign ptr_o = ptr_q;
  assign deg_o = deg_q;
  assign idx_o = idx_q;
  assign err_o = err_q;

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!deg_q && !fail_i) |=> (ptr_q != $past(ptr_q)));

  // R10
  sticky_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deg_q |=> (deg_q && $stable(idx_q)));

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $rose(deg_q));

endmodule

// File: rtl/gd_spare_adder.sv
module gd_spare_adder #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 4,
  localparam int W      = SEG_W * NUM_SEG,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             cin_i,
  input  logic [NUM_SEG-1:0] fault_i,
  output logic [W-1:0]     sum_o,
  output logic             cout_o,
  output logic             err_o,
  output logic [IDX_W-1:0] repl_idx_o,
  output logic             degraded_o
);
  localparam logic [SEG_W-1:0] TEST_A = '1;
  localparam logic [SEG_W-1:0] TEST_B = SEG_W'(1);

  // named internal events
  logic [NUM_SEG-1:0]            seg_cin;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_a, seg_b, seg_s;
  logic [NUM_SEG-1:0]            seg_ci, seg_co;
  logic [NUM_SEG-1:0]            slot_hot;
  logic [SEG_W-1:0]              spare_a, spare_b, spare_s;
  logic                          spare_ci, spare_co;
  logic [IDX_W-1:0]              ptr, idx, slot;
  logic                          deg, fail, err;
  logic [W-1:0]                  sum_d;
  logic                          cout_d;
  logic                          valid_q;

  gd_carry_tree #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_tree (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .seg_cin_o(seg_cin)
  );

  gd_rotor #(.NUM_SEG(NUM_SEG)) u_rotor (
    .clk(clk), .rst_n(rst_n), .fail_i(fail),
    .ptr_o(ptr), .deg_o(deg), .idx_o(idx), .err_o(err)
  );

  // slot served by the spare: rotating, or frozen once degraded
  assign slot = deg ? idx : ptr;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    assign slot_hot[i] = (slot == IDX_W'(i));
    assign seg_a[i]    = slot_hot[i] ? TEST_A : a_i[i*SEG_W +: SEG_W];
    assign seg_b[i]    = slot_hot[i] ? TEST_B : b_i[i*SEG_W +: SEG_W];
    assign seg_ci[i]   = slot_hot[i] ? 1'b0   : seg_cin[i];

    gd_ripple_seg #(.SEG_W(SEG_W)) u_seg (
      .a_i(seg_a[i]), .b_i(seg_b[i]), .ci_i(seg_ci[i]), .flip_i(fault_i[i]),
      .s_o(seg_s[i]), .co_o(seg_co[i])
    );

    assign sum_d[i*SEG_W +: SEG_W] = slot_hot[i] ? spare_s : seg_s[i];
  end

  assign spare_a  = a_i[slot*SEG_W +: SEG_W];
  assign spare_b  = b_i[slot*SEG_W +: SEG_W];
  assign spare_ci = seg_cin[slot];

  gd_ripple_seg #(.SEG_W(SEG_W)) u_spare (
    .a_i(spare_a), .b_i(spare_b), .ci_i(spare_ci), .flip_i(1'b0),
    .s_o(spare_s), .co_o(spare_co)
  );

  assign cout_d = slot_hot[NUM_SEG-1] ? spare_co : seg_co[NUM_SEG-1];

  gd_selftest #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_test (
    .seg_s_i(seg_s), .seg_co_i(seg_co), .idx_i(ptr), .enable_i(!deg), .fail_o(fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o   <= '0;
      cout_o  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sum_o   <= sum_d;
      cout_o  <= cout_d;
      valid_q <= 1'b1;
    end
  end

  assign err_o      = err;
  assign repl_idx_o = idx;
  assign degraded_o = deg;

  // R1
  clean_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(fault_i) == '0)) |->
      ({cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + (W+1)'($past(cin_i)))));

  // R6
  repl_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (repl_idx_o == $past(ptr)));

  // R8
  no_recheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    degraded_o |=> !err_o);

  // R4
  spare_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_hot) == 1);

endmodule

// File: tb/gd_spare_adder_test.sv
module gd_spare_adder_test;
  localparam int SW = 8;
  localparam int NS = 4;
  localparam int W  = SW * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic [NS-1:0] fault = '0;
  logic [W-1:0]  sum;
  logic          cout, err, deg;
  logic [1:0]    ridx;

  int n_run = 0, n_fail = 0;
  int mptr, midx, step_no, det_step;
  bit mdeg;
  logic [31:0] seed = 32'h1357_9bdf;

  gd_spare_adder #(.SEG_W(SW), .NUM_SEG(NS)) uut (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin), .fault_i(fault),
    .sum_o(sum), .cout_o(cout), .err_o(err), .repl_idx_o(ridx), .degraded_o(deg)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] rnd();
    seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]};
    return seed;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fault = '0; a = '0; b = '0; cin = 1'b0;
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {sum, cout, err, ridx, deg}, '0);
    rst_n = 1'b1;
    mptr = 0; midx = 0; mdeg = 0; step_no = 0; det_step = -1;
  endtask

  // one cycle: drive at negedge, check registered result at the next negedge
  task automatic step(input logic [W-1:0] xa, input logic [W-1:0] xb,
                      input logic xc, input logic [NS-1:0] xf, input string req);
    logic [W:0] full;
    bit exp_err;
    a = xa; b = xb; cin = xc; fault = xf;
    full = {1'b0, xa} + {1'b0, xb} + (W+1)'(xc);
    for (int i = 0; i < NS; i++) begin
      if (xf[i] && (i != (mdeg ? midx : mptr))) full[i*SW] = ~full[i*SW];
    end
    exp_err = !mdeg && xf[mptr];
    if (exp_err) begin
      mdeg = 1; midx = mptr;
    end else if (!mdeg) begin
      mptr = (mptr + 1) % NS;
    end
    @(negedge clk);
    chk({req, " sum/cout"}, {31'b0, cout, sum}, {31'b0, full});
    chk({req, " err"}, 64'(err), 64'(exp_err));
    chk({req, " degraded/index"}, {deg, ridx}, {mdeg, 2'(midx)});
    if (err) det_step = step_no;
    step_no++;
  endtask

  task automatic t_clean();
    do_reset();
    step(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, '0, "R1 full carry ripple");
    step(32'h00FF_00FF, 32'h0001_0001, 1'b1, '0, "R1 cross-segment carries");
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, '0, "R1 max operands");
    step(32'h0000_0000, 32'h0000_0000, 1'b0, '0, "R1 zero");
    for (int i = 0; i < 8; i++) step(rnd(), rnd(), rnd() % 2 == 1, '0, "R1 rotation random");
  endtask

  task automatic t_detect(input int k);
    int j;
    do_reset();
    for (int i = 0; i < 6; i++)
      step(rnd(), rnd(), 1'b0, NS'(1 << k), "R3 R4 held fault before detect");
    // R2 detection lands in the faulty segment's rotation slot
    chk("R2 detection cycle", 64'(det_step), 64'(k));
    // R6 index
    chk("R6 replaced index", 64'(ridx), 64'(k));
    for (int i = 0; i < 3; i++)
      step(rnd(), rnd(), 1'b1, NS'(1 << k), "R7 replaced segment fault masked");
    j = (k + 1) % NS;
    for (int i = 0; i < 4; i++)
      step(rnd(), rnd(), 1'b0, NS'(1 << j), "R8 unchecked fault passes");
    chk("R10 sticky degraded", 64'({deg, ridx}), 64'({1'b1, 2'(k)}));
  endtask

  task automatic t_restart();
    do_reset();
    chk("R10 reset clears degraded", 64'(deg), 64'(0));
    // transient fault on segment 2 while segment 0 is displaced: not detected
    step(32'h1234_5678, 32'h1111_1111, 1'b0, 4'b0100, "R3 fault visible in sum");
    step(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, '0, "R2 restart rotation");
    // segment 2 now displaced in cycle 2: detected, output clean
    step(32'h0F0F_0F0F, 32'hF0F0_F0F1, 1'b0, 4'b0100, "R4 R5 displaced fault");
    chk("R5 err pulse index", 64'(ridx), 64'(2));
    step(32'h0000_0001, 32'h0000_0001, 1'b0, '0, "R5 err drops after one cycle");
  endtask

  initial begin
    t_clean();
    for (int k = 0; k < NS; k++) t_detect(k);
    t_restart();
    finish_run();
  end

endmodule